// File: doc/BRIEF.md
# Dual-Mode Reload / PWM Timer

This block holds a set of independent 8-bit timer channels, two by default. Each channel has one counter that works in one of two ways. In interval mode the counter counts down and reloads itself; each reload flips the channel's output pin. In PWM mode the same counter runs freely upward and the pin shows a duty cycle. The PWM period is 128 or 256 counts, chosen by a resolution bit.

The counter does not advance on every clock. It advances only on cycles when the chosen bit of an externally supplied vector of prescaler strobes is high. Each channel picks its own strobe. Software programs a channel through a plain write strobe that carries a channel index, a register address and data. Each channel keeps a sticky event flag. Each channel's interrupt request is that flag gated by an enable bit.

Top module: `dual_timer`

## Requirements
- R1: After reset every channel is stopped, its registers are zero, and `pin_out` and `irq` are low.
- R2: A write with `wr_en` high updates only the channel named by `wr_ch`. Address 0 is control: bit0 run, bit1 PWM mode, bit2 7-bit resolution, bit3 interrupt enable, bits5:4 strobe select. Address 1 is the reload/compare value. A write to address 2 clears the event flag. Address 3 is ignored. A write is seen by the counter from the next cycle.
- R3: In interval mode, a count cycle that finds the counter at zero reloads it from the value register and toggles the pin. Any other count cycle decrements the counter. The pin toggles every value+1 count cycles.
- R4: A running channel counts only on cycles when `tap_en[sel]` is high. With the strobe period of 2^k clocks, the pin period scales by that factor.
- R5: In PWM mode the counter counts up, wrapping after 255 (8-bit) or 127 (7-bit). The pin is high while the count is below the active compare value, so the high time is compare counts per period. A compare value of 0 holds the pin low.
- R6: In 7-bit resolution only bits 6:0 of the compare value are used. For example, 200 gives 72 high counts per 128.
- R7: A value write while the channel runs has no effect on the current period. It is taken up at the next reload (interval mode) or at the wrap (PWM mode).
- R8: While a channel is stopped, its pin holds its last level. Its counter is preloaded from the value register in interval mode and cleared in PWM mode, and its active compare value is loaded from the value register.
- R9: The event flag sets on every reload or PWM wrap and stays set until a clear write. If an event and a clear fall in the same cycle, the flag stays set.
- R10: `irq[c]` is high exactly when channel c's flag is set and its interrupt enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tap_en | input | NUM_TAPS | Prescaler strobes, one per tap |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W | Channel addressed by the write |
| wr_addr | input | 2 | Register address (0 control, 1 value, 2 flag clear) |
| wr_data | input | W | Write data |
| pin_out | output | NUM_CH | Timer output pin per channel |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
The bench uses the defaults: two channels, four strobe inputs and an 8-bit counter. It drives strobe k as a pulse every 2^k clocks. With two channels, a write to one channel can be shown to leave the other untouched while both run. With four taps, the period scaling can be measured at a slow tap as well as the every-cycle tap. An 8-bit value range makes both the 128-count and the 256-count PWM periods short enough to count exactly, including the truncation of compare values above 127 in 7-bit mode.

// File: rtl/dual_timer_pkg.sv
// Shared types for the dual-mode timer: register addresses and the
// control register layout. Assumes strobe select fits in two bits.
package dual_timer_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_VAL  = 2'd1,
        ADDR_CLR  = 2'd2
    } reg_addr_e;

    // Control register, LSB first: run, pwm, res7, ien, sel[1:0]
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             ien;
        logic             res7;
        logic             pwm;
        logic             run;
    } ctrl_t;

endpackage

// File: rtl/tmr_tap_sel.sv
// Count-enable selection: picks one prescaler strobe by index and gates
// it with the run bit. Assumes select values at or above NUM_TAPS mean
// "never count".
module tmr_tap_sel #(
    parameter int NUM_TAPS = 4
) (
    input  logic [NUM_TAPS-1:0]              tap_en,
    input  logic [dual_timer_pkg::SEL_W-1:0] sel,
    input  logic                             run,
    output logic                             tick
);

    // Purpose: multiplex the chosen strobe onto the tick line.
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (int'(sel) == k) tick = run & tap_en[k];
        end
    end

endmodule

// File: rtl/tmr_regs.sv
// Per-channel register file: control, value and the sticky event flag.
// Assumes wr_en is already qualified by the channel index.
module tmr_regs #(
    parameter int W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [W-1:0]          wr_data,
    input  logic                  evt,
    output dual_timer_pkg::ctrl_t ctrl,
    output logic [W-1:0]          val,
    output logic                  flag
);
    import dual_timer_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    // Purpose: capture control and value writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            val  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_VAL:  val  <= wr_data;
                default:   ;
            endcase
        end
    end

    // Purpose: event flag, set has priority over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flag <= 1'b0;
        else if (evt)                            flag <= 1'b1;
        else if (wr_en && wr_addr == ADDR_CLR)   flag <= 1'b0;
    end

endmodule

// File: rtl/tmr_core.sv
// Shared counter for one channel: down-counting auto-reload with pin
// toggle, or up-counting PWM with 7- or 8-bit wrap. The value register
// is taken only at boundaries while running; stopped preloads state.
module tmr_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         pwm,
    input  logic         res7,
    input  logic         tick,
    input  logic [W-1:0] val,
    output logic         evt,
    output logic         out_q,
    output logic         cmp_is_zero
);

    localparam logic [W-1:0] FULL = {W{1'b1}};
    localparam logic [W-1:0] HALF = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] cnt, cnt_n;
    logic [W-1:0] cmp, cmp_n;
    logic [W-1:0] mask;
    logic         out_n;

    assign mask        = res7 ? HALF : FULL;
    assign cmp_is_zero = (cmp & mask) == '0;

    // Purpose: next counter, compare and pin state for both modes.
    always_comb begin
        cnt_n = cnt;
        cmp_n = cmp;
        out_n = out_q;
        evt   = 1'b0;
        if (!run) begin
            cnt_n = pwm ? '0 : val;
            cmp_n = val;
        end else if (!pwm) begin
            if (tick) begin
                if (cnt == '0) begin
                    evt   = 1'b1;
                    cnt_n = val;
                    out_n = ~out_q;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
        end else begin
            if (tick) begin
                if ((cnt & mask) == mask) begin
                    evt   = 1'b1;
                    cmp_n = val;
                end
                cnt_n = W'(cnt + 1'b1) & mask;
            end
            out_n = cnt_n < (cmp_n & mask);
        end
    end

    // Purpose: register counter, active compare and pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            cmp   <= '0;
            out_q <= 1'b0;
        end else begin
            cnt   <= cnt_n;
            cmp   <= cmp_n;
            out_q <= out_n;
        end
    end

endmodule

// File: rtl/dual_timer.sv
// Top: NUM_CH independent reload/PWM timer channels sharing one write
// port and one set of prescaler strobes. Assumes W >= 6 so the control
// fields fit in a data word.
module dual_timer #(
    parameter int NUM_CH   = 2,
    parameter int NUM_TAPS = 4,
    parameter int W        = 8,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] tap_en,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [1:0]          wr_addr,
    input  logic [W-1:0]        wr_data,
    output logic [NUM_CH-1:0]   pin_out,
    output logic [NUM_CH-1:0]   irq
);
    import dual_timer_pkg::*;

    logic [NUM_CH-1:0] run_v, pwm_v, evt_v, flag_v, clr_v, cmp0_v;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ctrl_t        ctrl;
        logic [W-1:0] val;
        logic         tick;
        logic         ch_wr;

        assign ch_wr = wr_en && (wr_ch == CH_W'(c));

        tmr_regs #(.W(W)) u_regs (
            .clk(clk), .rst_n(rst_n), .wr_en(ch_wr), .wr_addr(wr_addr),
            .wr_data(wr_data), .evt(evt_v[c]), .ctrl(ctrl), .val(val),
            .flag(flag_v[c])
        );

        tmr_tap_sel #(.NUM_TAPS(NUM_TAPS)) u_sel (
            .tap_en(tap_en), .sel(ctrl.sel), .run(ctrl.run), .tick(tick)
        );

        tmr_core #(.W(W)) u_core (
            .clk(clk), .rst_n(rst_n), .run(ctrl.run), .pwm(ctrl.pwm),
            .res7(ctrl.res7), .tick(tick), .val(val), .evt(evt_v[c]),
            .out_q(pin_out[c]), .cmp_is_zero(cmp0_v[c])
        );

        assign irq[c]   = flag_v[c] & ctrl.ien;
        assign run_v[c] = ctrl.run;
        assign pwm_v[c] = ctrl.pwm;
        assign clr_v[c] = ch_wr && (wr_addr == ADDR_CLR);
    end

endmodule

// File: rtl/timer_chk.sv
// Assertion checker for dual_timer, attached by bind below.
module timer_chk #(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] run_v,
    input logic [NUM_CH-1:0] pwm_v,
    input logic [NUM_CH-1:0] evt_v,
    input logic [NUM_CH-1:0] flag_v,
    input logic [NUM_CH-1:0] clr_v,
    input logic [NUM_CH-1:0] cmp0_v,
    input logic [NUM_CH-1:0] pin_out
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
        assert_reload_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_v[c] && !pwm_v[c]) |=> (pin_out[c] != $past(pin_out[c])));

        assert_pwm_zero_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (run_v[c] && pwm_v[c] && cmp0_v[c] && !evt_v[c]) |=> !pin_out[c]);

        assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !run_v[c] |=> $stable(pin_out[c]));

        assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
            evt_v[c] |=> flag_v[c]);

        assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_v[c] && !clr_v[c]) |=> flag_v[c]);

        assert_no_event_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !run_v[c] |-> !evt_v[c]);
    end

endmodule

bind dual_timer timer_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .run_v(run_v), .pwm_v(pwm_v), .evt_v(evt_v),
    .flag_v(flag_v), .clr_v(clr_v), .cmp0_v(cmp0_v), .pin_out(pin_out)
);

// File: tb/dual_timer_tb.sv
module dual_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int NT  = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [NT-1:0] tap_en = '0;
    logic          wr_en = 0;
    logic [0:0]    wr_ch = '0;
    logic [1:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [NCH-1:0] pin_out, irq;

    int checks = 0, errors = 0, cyc = 0;
    string phase = "R1";

    dual_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tap_en(tap_en), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_addr(wr_addr), .wr_data(wr_data), .pin_out(pin_out), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int m_run[NCH], m_pwm[NCH], m_res7[NCH], m_ien[NCH], m_sel[NCH];
    int m_val[NCH], m_cnt[NCH], m_cmp[NCH], m_out[NCH], m_flag[NCH];

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_run[c]=0; m_pwm[c]=0; m_res7[c]=0; m_ien[c]=0; m_sel[c]=0;
                m_val[c]=0; m_cnt[c]=0; m_cmp[c]=0; m_out[c]=0; m_flag[c]=0;
            end else begin
                int mask, tk, ev;
                mask = m_res7[c] ? 127 : 255;
                tk = tap_en[m_sel[c]];
                ev = 0;
                if (!m_run[c]) begin
                    m_cnt[c] = m_pwm[c] ? 0 : m_val[c];
                    m_cmp[c] = m_val[c];
                end else if (!m_pwm[c]) begin
                    if (tk) begin
                        if (m_cnt[c] == 0) begin
                            ev = 1; m_cnt[c] = m_val[c]; m_out[c] = 1 - m_out[c];
                        end else m_cnt[c] = m_cnt[c] - 1;
                    end
                end else begin
                    if (tk) begin
                        if ((m_cnt[c] & mask) == mask) begin ev = 1; m_cmp[c] = m_val[c]; end
                        m_cnt[c] = (m_cnt[c] + 1) & mask;
                    end
                    m_out[c] = (m_cnt[c] < (m_cmp[c] & mask)) ? 1 : 0;
                end
                if (ev) m_flag[c] = 1;
                else if (wr_en && wr_ch == c && wr_addr == 2) m_flag[c] = 0;
                if (wr_en && wr_ch == c) begin
                    if (wr_addr == 0) begin
                        m_run[c]=wr_data[0]; m_pwm[c]=wr_data[1]; m_res7[c]=wr_data[2];
                        m_ien[c]=wr_data[3]; m_sel[c]=int'(wr_data[5:4]);
                    end else if (wr_addr == 1) m_val[c] = wr_data;
                end
            end
        end
    end

    // compare every clock, away from the active edge; then advance strobes
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                checks++;
                if (pin_out[c] !== m_out[c][0] || irq[c] !== (m_flag[c][0] & m_ien[c][0])) begin
                    errors++;
                    $display("FAIL %s ch%0d pin=%b irq=%b expected pin=%0d irq=%0d", phase, c,
                             pin_out[c], irq[c], m_out[c], m_flag[c] & m_ien[c]);
                end
            end
        end
        cyc++;
        for (int k = 0; k < NT; k++) tap_en[k] = (cyc % (1 << k)) == 0;
    end

    task automatic wr(input int ch, input int addr, input int data);
        @(negedge clk);
        wr_en = 1; wr_ch = ch[0:0]; wr_addr = addr[1:0]; wr_data = data[7:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_high(input int ch, input int n, output int highs);
        highs = 0;
        repeat (n) begin @(negedge clk); #1; highs += pin_out[ch]; end
    endtask

    task automatic count_toggles(input int ch, input int n, output int tg);
        logic prev;
        tg = 0;
        @(negedge clk); #1; prev = pin_out[ch];
        repeat (n) begin @(negedge clk); #1; if (pin_out[ch] != prev) tg++; prev = pin_out[ch]; end
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        logic held;
        idle(5);
        rst_n = 1;
        @(negedge clk); #1;
        check("R1 pin", int'(pin_out), 0);
        check("R1 irq", int'(irq), 0);

        phase = "R3";
        wr(0, 1, 3); wr(0, 0, 8'h01); idle(4);
        count_toggles(0, 40, n); check("R3 toggles val=3", n, 10);

        phase = "R4";
        wr(0, 0, 8'h00); wr(0, 1, 1); wr(0, 0, 8'h21); idle(10);
        count_toggles(0, 80, n); check("R4 toggles tap2 val=1", n, 10);

        phase = "R5";
        wr(1, 1, 64); wr(1, 0, 8'h03); idle(10);
        count_high(1, 256, n); check("R5 duty 64/256", n, 64);
        count_toggles(0, 80, n); check("R2 ch0 unaffected by ch1", n, 10);

        phase = "R6";
        wr(1, 0, 8'h00); wr(1, 1, 32); wr(1, 0, 8'h07); idle(10);
        count_high(1, 128, n); check("R6 duty 32/128", n, 32);
        phase = "R7";
        wr(1, 1, 200); idle(130);
        count_high(1, 128, n); check("R6 R7 compare 200 -> 72/128", n, 72);

        phase = "R5";
        wr(1, 1, 0); idle(260);
        count_high(1, 256, n); check("R5 compare 0 stays low", n, 0);

        phase = "R7";
        wr(0, 0, 8'h00); wr(0, 1, 9); wr(0, 0, 8'h01); idle(3);
        wr(0, 1, 1); idle(20);
        count_toggles(0, 40, n); check("R7 new reload after boundary", n, 20);
        wr(0, 3, 8'hFF);
        count_toggles(0, 40, n); check("R2 address 3 ignored", n, 20);

        phase = "R8";
        wr(0, 0, 8'h00); wr(1, 0, 8'h00); #1;
        held = pin_out[0];
        count_toggles(0, 50, n); check("R8 stopped pin holds", n, 0);
        check("R8 held level", int'(pin_out[0]), int'(held));

        phase = "R10";
        check("R10 irq low while disabled", int'(irq[0]), 0);
        wr(0, 0, 8'h08); #1;
        check("R10 irq with flag and enable", int'(irq[0]), 1);
        phase = "R9";
        idle(20); #1;
        check("R9 flag stays set", int'(irq[0]), 1);
        wr(0, 2, 0); #1;
        check("R9 clear write", int'(irq[0]), 0);

        phase = "R9 random";
        for (int i = 0; i < 3000; i++) begin
            int a, d;
            a = $urandom_range(0, 3);
            d = (a == 1) ? $urandom_range(0, 12) : $urandom_range(0, 255);
            if (a == 0) d = d & 8'h1F | ($urandom_range(0, 1) << 4) | 8'h01;
            wr($urandom_range(0, 1), a, d);
            idle($urandom_range(0, 6));
        end
        idle(5);
        finish_run();
    end

endmodule